// File: doc/BRIEF.md
# Shadow Register Transfer Engine

This block keeps a bank of 32-bit configuration words that software writes over a simple host bus (the master bank), plus a second set of copies (the local bank) that the controlled logic actually uses. A master value never reaches its local copy on its own. Software moves it on purpose, either one word at a time through a write-control register, or as a batch by loading a bitmask and pulsing an auto-transfer start bit. Each completed copy sets a one-hot bit, indexed by word number, in a status register. A batch also raises a done flag when it finishes.

Only the low word region has local copies. The words at byte offset 0x80 and above are the engine's own control and status registers and exist only on the master side. A local copy is read back indirectly. Software writes the wanted word index into the readout-select word at 0x48 and copies that word to the local side. The readout-data register at 0x98 then shows the selected local copy.

The bus is single-cycle. A write is taken on the clock edge where `busWrEn` is high. Read data follows `busAddr` combinationally. Every copy takes `XFER_CYCLES` clock cycles, so the per-register time bound of the system holds whenever `XFER_CYCLES` times the clock period stays within it.

Top module: `shadow_xfer_engine`

## Requirements
- R1: After reset every local copy, the status register (0x94), the done flag (0x8C bit 0), the mask (0x80) and write-control (0x90) read as zero, and offset 0x00 always reads the `VERSION_VAL` parameter.
- R2: Master words at offsets 0x04..0x7C read back what was last written. Writes to offset 0x00 are ignored. A master write alone never changes a local copy.
- R3: In write-control (0x90), bit 0 is update-enable and bits [6:1] hold the target word index. A single transfer starts only on a write with bit 0 set when the register's previous bit 0 was clear. A second set without a clear in between starts nothing.
- R4: An accepted single transfer clears the status register on its request edge. It copies the master word to its local copy and sets status bit (1 << index) exactly `XFER_CYCLES` clock edges after the request edge. Word 0 copies the version value.
- R5: A single transfer whose index field is 32 or more (an offset at or above 0x80) is rejected. Status, local copies and the done flag do not change.
- R6: With readout-select (0x48) copied to the local side, 0x98 returns the local copy whose word index is held in the low 5 bits of that local readout-select copy.
- R7: An auto-transfer starts when bit 0 of 0x84 is written 1 after having been 0. On its start edge it clears status and the done flag, and it captures the mask at 0x80 (bit i selects word i).
- R8: An auto-transfer copies the selected words from the lowest index to the highest, one every `XFER_CYCLES` edges. Each copy sets its status bit.
- R9: With n mask bits set, done (0x8C bit 0) rises exactly n*`XFER_CYCLES`+1 edges after the start edge, and only 1 edge after it for an empty mask. It then stays set until the next accepted start.
- R10: While any transfer is in progress, new single or auto start requests are ignored. Mask writes made meanwhile do not alter the batch under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus, master and local banks |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe, taken on the rising clock edge |
| busAddr | input | ADDR_W | Byte offset for reads and writes |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data for `busAddr`, combinational |

## Verification
The bench builds the engine with `LOCAL_WORDS=32` and `XFER_CYCLES=3`. The full local window up to the 0x80 boundary is then present, so every word index can be swept by single transfer and readback, and index fields of 32 and above hit the real rejection edge. The short copy time keeps a full 32-bit-mask batch under a hundred cycles. Every completion edge, and the edge just before it, can be sampled exactly for single transfers, ordered batches, empty masks and requests made while busy.

// File: rtl/shadow_xfer_pkg.sv
package shadow_xfer_pkg;

  // Byte offsets of the master-only engine registers (fixed map)
  localparam int unsigned OFS_VERSION  = 32'h00;
  localparam int unsigned OFS_READSEL  = 32'h48;
  localparam int unsigned OFS_AUTOMASK = 32'h80;
  localparam int unsigned OFS_AUTOGO   = 32'h84;
  localparam int unsigned OFS_AUTOSTAT = 32'h8C;
  localparam int unsigned OFS_WRCTL    = 32'h90;
  localparam int unsigned OFS_WRSTAT   = 32'h94;
  localparam int unsigned OFS_READOUT  = 32'h98;

  // Strobes from the sequencer to the register datapath
  typedef struct packed {
    logic copyEn;   // copy master word copyIdx to its local copy this edge
    logic clrStat;  // clear per-word status
    logic clrDone;  // clear batch done flag
    logic setDone;  // raise batch done flag
  } xferStrb_t;

endpackage

// File: rtl/shadow_xfer_ctrl.sv
module shadow_xfer_ctrl
  import shadow_xfer_pkg::*;
#(
  parameter int LOCAL_WORDS = 32,
  parameter int XFER_CYCLES = 4,
  localparam int IDX_W = $clog2(LOCAL_WORDS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   singleReq,
  input  logic [IDX_W-1:0]       singleIdx,
  input  logic                   autoReq,
  input  logic [LOCAL_WORDS-1:0] autoMask,
  output xferStrb_t              strb,
  output logic [IDX_W-1:0]       copyIdx,
  output logic                   busy
);

  localparam int CNT_W = $clog2(XFER_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_RELOAD = CNT_W'(XFER_CYCLES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SINGLE, ST_AUTO} seqState_t;

  seqState_t              stateQ;
  logic [CNT_W-1:0]       cntQ;
  logic [IDX_W-1:0]       curIdxQ;
  logic [LOCAL_WORDS-1:0] pendQ;
  logic [IDX_W-1:0]       lowIdx;

  // Lowest pending word wins
  always_comb begin
    lowIdx = '0;
    for (int i = LOCAL_WORDS - 1; i >= 0; i--) begin
      if (pendQ[i]) lowIdx = IDX_W'(i);
    end
  end

  always_comb begin
    strb    = '0;
    copyIdx = curIdxQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (singleReq) begin
          strb.clrStat = 1'b1;
        end else if (autoReq) begin
          strb.clrStat = 1'b1;
          strb.clrDone = 1'b1;
        end
      end
      ST_SINGLE: begin
        if (cntQ == '0) strb.copyEn = 1'b1;
      end
      ST_AUTO: begin
        if (pendQ == '0) begin
          strb.setDone = 1'b1;
        end else if (cntQ == '0) begin
          strb.copyEn = 1'b1;
          copyIdx     = lowIdx;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      cntQ    <= '0;
      curIdxQ <= '0;
      pendQ   <= '0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (singleReq) begin
            stateQ  <= ST_SINGLE;
            curIdxQ <= singleIdx;
            cntQ    <= CNT_RELOAD;
          end else if (autoReq) begin
            stateQ <= ST_AUTO;
            pendQ  <= autoMask;
            cntQ   <= CNT_RELOAD;
          end
        end
        ST_SINGLE: begin
          if (cntQ == '0) stateQ <= ST_IDLE;
          else            cntQ   <= cntQ - 1'b1;
        end
        ST_AUTO: begin
          if (pendQ == '0) begin
            stateQ <= ST_IDLE;
          end else if (cntQ == '0) begin
            pendQ <= pendQ & ~(LOCAL_WORDS'(1) << lowIdx);
            cntQ  <= CNT_RELOAD;
          end else begin
            cntQ <= cntQ - 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign busy = (stateQ != ST_IDLE);

endmodule

// File: rtl/shadow_xfer_dpath.sv
module shadow_xfer_dpath
  import shadow_xfer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int LOCAL_WORDS = 32,
  parameter logic [DATA_W-1:0] VERSION_VAL = 32'h0002_0003,
  localparam int IDX_W = $clog2(LOCAL_WORDS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busWrEn,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [DATA_W-1:0]      busWrData,
  output logic [DATA_W-1:0]      busRdData,
  input  xferStrb_t              strb,
  input  logic [IDX_W-1:0]       copyIdx,
  output logic                   singleReq,
  output logic [IDX_W-1:0]       singleIdx,
  output logic                   autoReq,
  output logic [LOCAL_WORDS-1:0] autoMask,
  output logic [LOCAL_WORDS-1:0] wrStatus,
  output logic                   autoDone
);

  localparam int WORD_W = ADDR_W - 2;
  localparam int SEL_W  = IDX_W + 1;
  localparam logic [WORD_W-1:0] WORD_LIMIT  = WORD_W'(LOCAL_WORDS);
  localparam logic [SEL_W-1:0]  SEL_LIMIT   = SEL_W'(LOCAL_WORDS);
  localparam int                READSEL_IDX = OFS_READSEL / 4;

  logic [DATA_W-1:0] masterQ [LOCAL_WORDS];
  logic [DATA_W-1:0] localQ  [LOCAL_WORDS];
  logic [DATA_W-1:0] wrCtlQ;
  logic              autoGoQ;
  logic [WORD_W-1:0] wordIdx;
  logic              inLocalWin;
  logic [SEL_W-1:0]  selField;
  logic [IDX_W-1:0]  readoutSel;

  assign wordIdx    = busAddr[ADDR_W-1:2];
  assign inLocalWin = (wordIdx < WORD_LIMIT);
  assign selField   = busWrData[SEL_W:1];

  // Request detection: set after clear, index inside the local window
  assign singleReq = busWrEn && (busAddr == ADDR_W'(OFS_WRCTL)) && busWrData[0]
                     && !wrCtlQ[0] && (selField < SEL_LIMIT);
  assign singleIdx = selField[IDX_W-1:0];
  assign autoReq   = busWrEn && (busAddr == ADDR_W'(OFS_AUTOGO)) && busWrData[0] && !autoGoQ;

  genvar gw;
  generate
    for (gw = 0; gw < LOCAL_WORDS; gw++) begin : g_word
      if (gw == 0) begin : g_ver
        assign masterQ[gw] = VERSION_VAL;
      end else begin : g_rw
        always_ff @(posedge clk) begin
          if (!rstN) masterQ[gw] <= '0;
          else if (busWrEn && inLocalWin && (wordIdx == WORD_W'(gw)))
            masterQ[gw] <= busWrData;
        end
      end
      always_ff @(posedge clk) begin
        if (!rstN) localQ[gw] <= '0;
        else if (strb.copyEn && (copyIdx == IDX_W'(gw)))
          localQ[gw] <= masterQ[gw];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrCtlQ   <= '0;
      autoGoQ  <= 1'b0;
      autoMask <= '0;
      wrStatus <= '0;
      autoDone <= 1'b0;
    end else begin
      if (busWrEn && (busAddr == ADDR_W'(OFS_WRCTL)))    wrCtlQ   <= busWrData;
      if (busWrEn && (busAddr == ADDR_W'(OFS_AUTOGO)))   autoGoQ  <= busWrData[0];
      if (busWrEn && (busAddr == ADDR_W'(OFS_AUTOMASK))) autoMask <= busWrData[LOCAL_WORDS-1:0];
      if (strb.clrStat)     wrStatus <= '0;
      else if (strb.copyEn) wrStatus <= wrStatus | (LOCAL_WORDS'(1) << copyIdx);
      if (strb.clrDone)      autoDone <= 1'b0;
      else if (strb.setDone) autoDone <= 1'b1;
    end
  end

  assign readoutSel = localQ[READSEL_IDX][IDX_W-1:0];

  always_comb begin
    busRdData = '0;
    if (inLocalWin) begin
      busRdData = masterQ[wordIdx[IDX_W-1:0]];
    end else begin
      unique case (busAddr)
        ADDR_W'(OFS_AUTOMASK): busRdData = DATA_W'(autoMask);
        ADDR_W'(OFS_AUTOGO):   busRdData = DATA_W'(autoGoQ);
        ADDR_W'(OFS_AUTOSTAT): busRdData = DATA_W'(autoDone);
        ADDR_W'(OFS_WRCTL):    busRdData = wrCtlQ;
        ADDR_W'(OFS_WRSTAT):   busRdData = DATA_W'(wrStatus);
        ADDR_W'(OFS_READOUT):  busRdData = localQ[readoutSel];
        default:               busRdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/shadow_xfer_engine.sv
module shadow_xfer_engine
  import shadow_xfer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int LOCAL_WORDS = 32,
  parameter int XFER_CYCLES = 4,
  parameter logic [DATA_W-1:0] VERSION_VAL = 32'h0002_0003
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData
);

  localparam int IDX_W = $clog2(LOCAL_WORDS);

  xferStrb_t              ctlStrb;
  logic [IDX_W-1:0]       copyIdx;
  logic                   xferBusy;
  logic                   singleReq;
  logic [IDX_W-1:0]       singleIdx;
  logic                   autoReq;
  logic [LOCAL_WORDS-1:0] autoMask;
  logic [LOCAL_WORDS-1:0] wrStatus;
  logic                   autoDone;

  shadow_xfer_ctrl #(
    .LOCAL_WORDS(LOCAL_WORDS),
    .XFER_CYCLES(XFER_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .singleReq(singleReq), .singleIdx(singleIdx),
    .autoReq(autoReq), .autoMask(autoMask),
    .strb(ctlStrb), .copyIdx(copyIdx), .busy(xferBusy)
  );

  shadow_xfer_dpath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .LOCAL_WORDS(LOCAL_WORDS), .VERSION_VAL(VERSION_VAL)
  ) u_dpath (
    .clk(clk), .rstN(rstN),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .strb(ctlStrb), .copyIdx(copyIdx),
    .singleReq(singleReq), .singleIdx(singleIdx),
    .autoReq(autoReq), .autoMask(autoMask),
    .wrStatus(wrStatus), .autoDone(autoDone)
  );

endmodule

// File: rtl/shadow_xfer_checker.sv
module shadow_xfer_checker
  import shadow_xfer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int LOCAL_WORDS = 32,
  parameter logic [DATA_W-1:0] VERSION_VAL = 32'h0002_0003
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   busWrEn,
  input logic [ADDR_W-1:0]      busAddr,
  input logic [DATA_W-1:0]      busWrData,
  input logic [DATA_W-1:0]      busRdData,
  input xferStrb_t              strb,
  input logic                   busy,
  input logic [LOCAL_WORDS-1:0] wrStatus,
  input logic                   autoDone
);

  localparam int SEL_W = $clog2(LOCAL_WORDS) + 1;

  AST_VERSION_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(OFS_VERSION)) |-> (busRdData == VERSION_VAL)); // R1

  AST_STATUS_ONE_NEW_BIT: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrStat |=> ($countones(wrStatus & ~$past(wrStatus)) <= 1)); // R4

  AST_STATUS_NO_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrStat |=> (($past(wrStatus) & ~wrStatus) == '0)); // R4

  AST_HIGH_INDEX_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (busAddr == ADDR_W'(OFS_WRCTL)) && busWrData[0]
     && (busWrData[SEL_W:1] >= SEL_W'(LOCAL_WORDS))) |-> !strb.clrStat); // R5

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (autoDone && !strb.clrDone) |=> autoDone); // R9

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strb.clrStat || strb.clrDone)); // R10

  AST_COPY_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strb.copyEn |-> busy); // R8

endmodule

bind shadow_xfer_engine shadow_xfer_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .LOCAL_WORDS(LOCAL_WORDS), .VERSION_VAL(VERSION_VAL)
) u_chk (
  .clk(clk), .rstN(rstN),
  .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
  .strb(ctlStrb), .busy(xferBusy), .wrStatus(wrStatus), .autoDone(autoDone)
);

// File: tb/shadow_xfer_engine_tb.sv
module shadow_xfer_engine_tb;

  localparam int          DW  = 32;
  localparam int          AW  = 8;
  localparam int          LW  = 32;
  localparam int          XC  = 3;
  localparam logic [31:0] VER = 32'h0002_0003;

  logic          clk = 1'b0;
  logic          rstN;
  logic          busWrEn;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busWrData;
  logic [DW-1:0] busRdData;

  int errs = 0;
  int checks = 0;
  int cycles = 0;

  logic [31:0] masterM [LW];
  logic [31:0] localM  [LW];

  always #5 clk = ~clk;

  shadow_xfer_engine #(
    .DATA_W(DW), .ADDR_W(AW), .LOCAL_WORDS(LW),
    .XFER_CYCLES(XC), .VERSION_VAL(VER)
  ) u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; write is taken on the next posedge; returns at the following negedge
  task automatic wr(input int unsigned a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = AW'(a); busWrData = d;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input int unsigned a, output logic [31:0] d);
    busAddr = AW'(a);
    #1 d = busRdData;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic single(input int idx);
    wr(32'h90, 32'h0);
    wr(32'h90, (32'(idx) << 1) | 32'h1);
  endtask

  task automatic readLocal(input int idx, output logic [31:0] d);
    wr(32'h48, 32'(idx));
    masterM[18] = 32'(idx);
    single(18);
    localM[18] = 32'(idx);
    waitEdges(XC);
    rd(32'h98, d);
  endtask

  function automatic logic [31:0] pat(input int k);
    return 32'hC300_0000 ^ (32'(k) * 32'h0001_0305);
  endfunction

  initial begin
    logic [31:0] v;
    busWrEn = 1'b0; busAddr = '0; busWrData = '0; rstN = 1'b0;
    for (int i = 0; i < LW; i++) begin masterM[i] = '0; localM[i] = '0; end
    masterM[0] = VER;
    waitEdges(3);
    rstN = 1'b1;
    waitEdges(1);

    // R1 reset state
    rd(32'h94, v); check("R1 status", v, 32'h0);
    rd(32'h8C, v); check("R1 done", v, 32'h0);
    rd(32'h80, v); check("R1 mask", v, 32'h0);
    rd(32'h90, v); check("R1 wrctl", v, 32'h0);
    rd(32'h00, v); check("R1 version", v, VER);
    readLocal(7, v); check("R1 local zero", v, 32'h0);

    // R4/R6 sweep every index
    for (int k = 0; k < LW; k++) begin
      wr(32'(k) * 4, pat(k));
      if (k != 0) masterM[k] = pat(k);
      rd(32'(k) * 4, v); check("R2 master readback", v, masterM[k]);
      single(k);
      waitEdges(XC - 1);
      rd(32'h94, v); check("R4 status before", v, 32'h0);
      waitEdges(1);
      rd(32'h94, v); check("R4 status onehot", v, 32'h1 << k);
      localM[k] = masterM[k];
      readLocal(k, v); check("R6 readout", v, localM[k]);
    end

    // R2 master write does not touch local; version read-only
    wr(32'h14, 32'hDEAD_0005);
    rd(32'h14, v); check("R2 master write", v, 32'hDEAD_0005);
    masterM[5] = 32'hDEAD_0005;
    readLocal(5, v); check("R2 local untouched", v, localM[5]);
    wr(32'h00, 32'hFFFF_FFFF);
    rd(32'h00, v); check("R2 version ignores write", v, VER);

    // R5 reject indices 32 and 63
    wr(32'h90, 32'h0);
    wr(32'h90, (32'd32 << 1) | 32'h1);
    waitEdges(XC + 2);
    rd(32'h94, v); check("R5 reject 32", v, 32'h1 << 18);
    wr(32'h90, 32'h0);
    wr(32'h90, (32'd63 << 1) | 32'h1);
    waitEdges(XC + 2);
    rd(32'h94, v); check("R5 reject 63", v, 32'h1 << 18);

    // R3 set without prior clear is ignored (wrctl bit0 still 1)
    wr(32'h90, (32'd5 << 1) | 32'h1);
    waitEdges(XC + 2);
    rd(32'h94, v); check("R3 no restart", v, 32'h1 << 18);
    rd(32'h90, v); check("R3 wrctl field", v, (32'd5 << 1) | 32'h1);

    // R7/R8/R9 ordered batch, mask 0x16
    for (int i = 1; i < LW; i++) begin wr(32'(i) * 4, pat(i) ^ 32'h00FF_0000); masterM[i] = pat(i) ^ 32'h00FF_0000; end
    wr(32'h80, 32'h16);
    wr(32'h84, 32'h0);
    wr(32'h84, 32'h1);
    rd(32'h94, v); check("R7 status cleared at start", v, 32'h0);
    waitEdges(XC);
    rd(32'h94, v); check("R8 order step1", v, 32'h02);
    waitEdges(XC);
    rd(32'h94, v); check("R8 order step2", v, 32'h06);
    waitEdges(XC);
    rd(32'h94, v); check("R8 order step3", v, 32'h16);
    rd(32'h8C, v); check("R9 done not yet", v, 32'h0);
    waitEdges(1);
    rd(32'h8C, v); check("R9 done on time", v, 32'h1);
    localM[1] = masterM[1]; localM[2] = masterM[2]; localM[4] = masterM[4];
    // R9 repeated start without clear ignored
    wr(32'h84, 32'h1);
    waitEdges(2);
    rd(32'h8C, v); check("R9 done sticky", v, 32'h1);
    rd(32'h94, v); check("R7 no restart", v, 32'h16);
    readLocal(4, v); check("R7 batch copied", v, localM[4]);
    readLocal(3, v); check("R7 unmasked kept", v, localM[3]);

    // R9 empty mask
    wr(32'h80, 32'h0);
    wr(32'h84, 32'h0);
    wr(32'h84, 32'h1);
    rd(32'h8C, v); check("R9 empty cleared", v, 32'h0);
    waitEdges(1);
    rd(32'h8C, v); check("R9 empty done", v, 32'h1);
    rd(32'h94, v); check("R9 empty status", v, 32'h0);

    // R8 full mask, all words including version
    wr(32'h80, 32'hFFFF_FFFF);
    wr(32'h84, 32'h0);
    wr(32'h84, 32'h1);
    waitEdges(LW * XC);
    rd(32'h8C, v); check("R9 full not yet", v, 32'h0);
    waitEdges(1);
    rd(32'h8C, v); check("R9 full done", v, 32'h1);
    rd(32'h94, v); check("R8 full status", v, 32'hFFFF_FFFF);
    for (int i = 0; i < LW; i++) localM[i] = masterM[i];
    readLocal(0, v); check("R4 word0 version", v, VER);
    readLocal(31, v); check("R8 top word", v, localM[31]);

    // R10 requests while busy ignored
    wr(32'h80, 32'hF0);
    wr(32'h84, 32'h0);
    wr(32'h84, 32'h1);
    wr(32'h90, 32'h0);
    wr(32'h90, (32'd2 << 1) | 32'h1);
    wr(32'h80, 32'h1);
    wr(32'h84, 32'h0);
    wr(32'h84, 32'h1);
    waitEdges(20);
    rd(32'h94, v); check("R10 busy ignore", v, 32'hF0);
    rd(32'h8C, v); check("R10 done after batch", v, 32'h1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule